// File: doc/BRIEF.md
# Timebase Compare/Capture Array

This block is one 16-bit counter shared by five identical channels. Each channel can do one of four things, chosen by its mode register. It can latch the counter when its input pin changes. It can act as a software timer that raises a flag when the counter reaches a stored value. It can toggle its output pin on that same match. It can produce an 8-bit pulse-width-modulated output. The counter only advances when its run bit is set and the selected count source fires. There are four sources to choose from: two internal prescaler rates, a one-cycle overflow pulse from a neighbouring timer, and rising edges on an external count pin.

Software reaches every setting, compare value and captured value through a plain register port. A write is a single-cycle strobe. A read is a combinational mux on the read address. The port takes a write every cycle, so it has no valid/ready handshake and never applies back-pressure.

All channel events and the counter wrap set sticky flags. Each flag is gated by its own enable, and the gated flags are merged onto one interrupt output.

Top module: `cc_array`

## Requirements
- R1: After reset, every register reads as zero, every channel pin output is low and `irq` is low.
- R2: The control register sits at address 0. Bits [1:0] choose the count source. With 00 the counter steps once every sixth clock. With 01 it steps once every second clock. With 10 it steps once for each cycle in which `tmr_ovf_in` is high. With 11 it steps once for each rising edge of `ext_cnt_in`, counted after a two-flop synchronizer, so one edge gives exactly one step. When the counter steps, it rises by exactly one.
- R3: Control bit 2 is the run bit. While it is clear, the counter holds its value. The counter can be read and written at address 2, and a write takes priority over a step in the same cycle.
- R4: When the counter steps from 0xFFFF to 0x0000, it sets the overflow flag. This flag is bit 5 of the flag register at address 1.
- R5: The mode register of channel i sits at address 8+i. Bits [2:0] = 001 select capture. Bit 3 enables rising edges and bit 4 enables falling edges. On an enabled edge of the synchronized channel pin, the channel copies the counter into its value register at address 16+i and sets flag bit i.
- R6: Mode 010 is the software timer. It sets flag bit i on the clock edge where the counter steps onto the value register of channel i.
- R7: Mode 011 acts on the same match as R6. It sets flag bit i and also inverts the channel pin output.
- R8: Mode 100 is PWM. The channel pin is low while the counter's low byte is below a shadow byte, and high otherwise. The shadow byte reloads from the high byte of the value register only when the counter steps past a low byte of 0xFF.
- R9: Flags stay set until cleared. A write to address 1 clears each flag whose data bit is 1. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq` is high exactly when some flag bit i is set while bit 5 of mode register i is set, or when the overflow flag is set while control bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| tmr_ovf_in | input | 1 | One-cycle overflow pulse from another timer (source 10) |
| ext_cnt_in | input | 1 | External count pin (source 11), asynchronous |
| ch_pin_in | input | 5 | Per-channel capture pins, asynchronous |
| ch_pin_out | output | 5 | Per-channel toggle/PWM outputs |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a counter wrap and a channel compare match landing on the same clock edge. A close second is a flag clear that collides with a new set of the same flag. The bench stops the counter and writes it to a value just below 0xFFFF. It then picks the neighbouring-timer pulse as the count source, so each pulse moves the counter by exactly one step. It drives the final pulse in the same cycle as the flag-clear write. A behavioural model in the bench follows every clock and compares the pins and `irq` against the design on each cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [2:0] {
    FN_IDLE   = 3'd0,
    FN_CAPT   = 3'd1,
    FN_TIMER  = 3'd2,
    FN_TOGGLE = 3'd3,
    FN_PWM    = 3'd4
  } fn_e;

  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
    fn_e  fn;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam int ADDR_CTRL      = 0;
  localparam int ADDR_FLAG      = 1;
  localparam int ADDR_CNT       = 2;
  localparam int ADDR_MODE_BASE = 8;
  localparam int ADDR_VAL_BASE  = 16;

  localparam logic [1:0] SRC_SLOW = 2'b00;
  localparam logic [1:0] SRC_FAST = 2'b01;
  localparam logic [1:0] SRC_TMR  = 2'b10;
  localparam logic [1:0] SRC_EXT  = 2'b11;

endpackage

// File: rtl/cc_tick.sv
module cc_tick
  import cc_pkg::*;
#(
  parameter int DIV_SLOW = 6,
  parameter int DIV_FAST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       tmr_ovf,
  input  logic       ext_cnt,
  output logic       tick
);

  localparam int SW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam int FW = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;
  localparam logic [SW-1:0] SLOW_LAST = SW'(DIV_SLOW - 1);
  localparam logic [FW-1:0] FAST_LAST = FW'(DIV_FAST - 1);

  logic [SW-1:0] slow_q;
  logic [FW-1:0] fast_q;
  logic [2:0]    ext_sh;
  logic          slow_hit, fast_hit, ext_rise;

  assign slow_hit = (slow_q == SLOW_LAST);
  assign fast_hit = (fast_q == FAST_LAST);
  assign ext_rise = ext_sh[1] & ~ext_sh[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_q <= '0;
      fast_q <= '0;
      ext_sh <= '0;
    end else begin
      slow_q <= slow_hit ? '0 : slow_q + SW'(1);
      fast_q <= fast_hit ? '0 : fast_q + FW'(1);
      ext_sh <= {ext_sh[1:0], ext_cnt};
    end
  end

  always_comb begin
    unique case (sel)
      SRC_SLOW: tick = slow_hit;
      SRC_FAST: tick = fast_hit;
      SRC_TMR:  tick = tmr_ovf;
      default:  tick = ext_rise;
    endcase
  end

endmodule

// File: rtl/cc_chan.sv
module cc_chan
  import cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_t        mode,
  input  logic         val_wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] cnt,
  input  logic         inc,
  input  logic         pin_in,
  output logic [W-1:0] val,
  output logic         event_o,
  output logic         pin_out
);

  localparam int PW = W / 2;

  logic [2:0]    pin_sh;
  logic [W-1:0]  val_q;
  logic [PW-1:0] shadow_q;
  logic          tog_q;
  logic          pin_edge, take, cap_ev, match, cmp_ev;
  logic [W-1:0]  cnt_nxt;

  assign pin_edge = pin_sh[1] ^ pin_sh[2];
  assign take     = pin_edge & ((pin_sh[1] & mode.rise_en) | (~pin_sh[1] & mode.fall_en));
  assign cap_ev   = (mode.fn == FN_CAPT) & take;
  assign cnt_nxt  = cnt + W'(1);
  assign match    = inc & (cnt_nxt == val_q);
  assign cmp_ev   = ((mode.fn == FN_TIMER) | (mode.fn == FN_TOGGLE)) & match;
  assign event_o  = cap_ev | cmp_ev;
  assign val      = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_sh   <= '0;
      val_q    <= '0;
      shadow_q <= '0;
      tog_q    <= 1'b0;
    end else begin
      pin_sh <= {pin_sh[1:0], pin_in};
      if (val_wr)      val_q <= wr_data;
      else if (cap_ev) val_q <= cnt;
      if (inc && (cnt[PW-1:0] == '1)) shadow_q <= val_q[W-1:PW];
      if ((mode.fn == FN_TOGGLE) && match) tog_q <= ~tog_q;
    end
  end

  always_comb begin
    if (mode.fn == FN_PWM)         pin_out = (cnt[PW-1:0] >= shadow_q);
    else if (mode.fn == FN_TOGGLE) pin_out = tog_q;
    else                           pin_out = 1'b0;
  end

endmodule

// File: rtl/cc_array.sv
module cc_array
  import cc_pkg::*;
#(
  parameter int NUM_CH   = 5,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 5,
  parameter int DIV_SLOW = 6,
  parameter int DIV_FAST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              tmr_ovf_in,
  input  logic              ext_cnt_in,
  input  logic [NUM_CH-1:0] ch_pin_in,
  output logic [NUM_CH-1:0] ch_pin_out,
  output logic              irq
);

  localparam int FLAG_W = NUM_CH + 1;

  logic [1:0]        sel_q;
  logic              run_q, ovf_ie_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FLAG_W-1:0] flags_q, flag_set, flag_clr, irq_mask;
  mode_t             mode_q [NUM_CH];
  logic [CNT_W-1:0]  val_w  [NUM_CH];
  logic [NUM_CH-1:0] ch_ev, val_wr, mode_wr;
  logic              tick, inc, wrap, ctrl_wr, flag_wr, cnt_wr;

  assign ctrl_wr = wr_en & (wr_addr == ADDR_W'(ADDR_CTRL));
  assign flag_wr = wr_en & (wr_addr == ADDR_W'(ADDR_FLAG));
  assign cnt_wr  = wr_en & (wr_addr == ADDR_W'(ADDR_CNT));

  cc_tick #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel_q),
    .tmr_ovf (tmr_ovf_in),
    .ext_cnt (ext_cnt_in),
    .tick    (tick)
  );

  assign inc  = run_q & tick;
  assign wrap = inc & (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      run_q    <= 1'b0;
      ovf_ie_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        sel_q    <= wr_data[1:0];
        run_q    <= wr_data[2];
        ovf_ie_q <= wr_data[3];
      end
      if (cnt_wr)   cnt_q <= wr_data;
      else if (inc) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign mode_wr[i] = wr_en & (wr_addr == ADDR_W'(ADDR_MODE_BASE + i));
    assign val_wr[i]  = wr_en & (wr_addr == ADDR_W'(ADDR_VAL_BASE + i));

    always_ff @(posedge clk) begin
      if (!rst_n)          mode_q[i] <= '0;
      else if (mode_wr[i]) mode_q[i] <= mode_t'(wr_data[MODE_W-1:0]);
    end

    cc_chan #(.W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q[i]),
      .val_wr  (val_wr[i]),
      .wr_data (wr_data),
      .cnt     (cnt_q),
      .inc     (inc),
      .pin_in  (ch_pin_in[i]),
      .val     (val_w[i]),
      .event_o (ch_ev[i]),
      .pin_out (ch_pin_out[i])
    );

    assign irq_mask[i] = mode_q[i].irq_en;
  end

  assign irq_mask[NUM_CH] = ovf_ie_q;
  assign flag_set = {wrap, ch_ev};
  assign flag_clr = flag_wr ? wr_data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq = |(flags_q & irq_mask);

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_CTRL)) rd_data = CNT_W'({ovf_ie_q, run_q, sel_q});
    if (rd_addr == ADDR_W'(ADDR_FLAG)) rd_data = CNT_W'(flags_q);
    if (rd_addr == ADDR_W'(ADDR_CNT))  rd_data = cnt_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(ADDR_MODE_BASE + i)) rd_data = CNT_W'(mode_q[i]);
      if (rd_addr == ADDR_W'(ADDR_VAL_BASE + i))  rd_data = val_w[i];
    end
  end

endmodule

// File: rtl/cc_array_chk.sv
module cc_array_chk
  import cc_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              inc,
  input logic              run_q,
  input logic [NUM_CH:0]   flags_q,
  input logic [NUM_CH:0]   irq_mask,
  input logic              irq
);

  logic chk_cnt_wr, chk_flag_wr;
  assign chk_cnt_wr  = wr_en & (wr_addr == ADDR_W'(ADDR_CNT));
  assign chk_flag_wr = wr_en & (wr_addr == ADDR_W'(ADDR_FLAG)) & (wr_data[NUM_CH:0] != '0);

  p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !chk_cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !chk_cnt_wr) |=> (cnt_q == $past(cnt_q)));

  p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !chk_cnt_wr && (cnt_q == '1)) |=> flags_q[NUM_CH]);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_flag_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != '0));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

endmodule

bind cc_array cc_array_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cc_array_bench.sv
module cc_array_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tmr_ovf_in = 1'b0;
  logic        ext_cnt_in = 1'b0;
  logic [4:0]  ch_pin_in = '0;
  logic [4:0]  ch_pin_out;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit live = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_array u_cc_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_ovf_in(tmr_ovf_in), .ext_cnt_in(ext_cnt_in),
    .ch_pin_in(ch_pin_in), .ch_pin_out(ch_pin_out), .irq(irq)
  );

  // behavioural reference model
  int m_cnt, m_sel, m_run, m_oie, m_flags, m_slow, m_fast;
  int m_val [NCH];
  int m_mode[NCH];
  int m_shd [NCH];
  bit m_tog [NCH];
  bit e1, e2, e3;
  bit p1[NCH], p2[NCH], p3[NCH];

  always @(posedge clk) begin : model
    bit tk, inc, ev, edge_ok;
    int fn, set, clr, wd;
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_run = 0; m_oie = 0; m_flags = 0; m_slow = 0; m_fast = 0;
      e1 = 0; e2 = 0; e3 = 0;
      for (int i = 0; i < NCH; i++) begin
        m_val[i] = 0; m_mode[i] = 0; m_shd[i] = 0; m_tog[i] = 0; p1[i] = 0; p2[i] = 0; p3[i] = 0;
      end
    end else begin
      wd = int'(wr_data);
      case (m_sel)
        0: tk = (m_slow == 5);
        1: tk = (m_fast == 1);
        2: tk = tmr_ovf_in;
        default: tk = e2 && !e3;
      endcase
      inc = m_run && tk;
      set = (inc && m_cnt == 65535) ? (1 << NCH) : 0;
      for (int i = 0; i < NCH; i++) begin
        fn = m_mode[i] & 7;
        ev = 0;
        edge_ok = (p2[i] != p3[i]) && ((p2[i] && m_mode[i][3]) || (!p2[i] && m_mode[i][4]));
        if (fn == 1 && edge_ok) ev = 1;
        if ((fn == 2 || fn == 3) && inc && (((m_cnt + 1) & 65535) == m_val[i])) begin
          ev = 1;
          if (fn == 3) m_tog[i] = !m_tog[i];
        end
        if (inc && (m_cnt & 255) == 255) m_shd[i] = m_val[i] >> 8;
        if (wr_en && wr_addr == 5'(16 + i)) m_val[i] = wd;
        else if (fn == 1 && edge_ok) m_val[i] = m_cnt;
        if (wr_en && wr_addr == 5'(8 + i)) m_mode[i] = wd & 63;
        if (ev) set |= (1 << i);
      end
      clr = (wr_en && wr_addr == 5'd1) ? (wd & 63) : 0;
      m_flags = (m_flags & ~clr) | set;
      if (wr_en && wr_addr == 5'd2) m_cnt = wd;
      else if (inc) m_cnt = (m_cnt + 1) & 65535;
      if (wr_en && wr_addr == 5'd0) begin
        m_sel = wd & 3; m_run = (wd >> 2) & 1; m_oie = (wd >> 3) & 1;
      end
      m_slow = (m_slow == 5) ? 0 : m_slow + 1;
      m_fast = (m_fast == 1) ? 0 : m_fast + 1;
      e3 = e2; e2 = e1; e1 = ext_cnt_in;
      for (int i = 0; i < NCH; i++) begin
        p3[i] = p2[i]; p2[i] = p1[i]; p1[i] = ch_pin_in[i];
      end
    end
  end

  function automatic int m_read(input logic [4:0] a);
    if (a == 0) return m_sel | (m_run << 2) | (m_oie << 3);
    if (a == 1) return m_flags;
    if (a == 2) return m_cnt;
    for (int i = 0; i < NCH; i++) begin
      if (a == 5'(8 + i))  return m_mode[i];
      if (a == 5'(16 + i)) return m_val[i];
    end
    return 0;
  endfunction

  function automatic logic [4:0] m_pins();
    logic [4:0] p;
    for (int i = 0; i < NCH; i++) begin
      if ((m_mode[i] & 7) == 4)      p[i] = ((m_cnt & 255) >= m_shd[i]);
      else if ((m_mode[i] & 7) == 3) p[i] = m_tog[i];
      else                           p[i] = 1'b0;
    end
    return p;
  endfunction

  function automatic logic m_irq();
    logic r = 1'b0;
    for (int i = 0; i < NCH; i++) if (m_flags[i] && m_mode[i][5]) r = 1'b1;
    if (m_flags[NCH] && m_oie != 0) r = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, output logic [15:0] v);
    rd_addr = a; #1;
    v = rd_data;
    chk(tag, {16'h0, rd_data}, 32'(m_read(a)));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tmr(input int n);
    repeat (n) begin
      tmr_ovf_in = 1'b1; @(negedge clk);
      tmr_ovf_in = 1'b0; @(negedge clk);
    end
  endtask

  // every-cycle comparison of pins and interrupt (R7 R8 R10)
  always @(negedge clk) begin
    if (rst_n && live) begin
      chk("R7 R8 pins", {27'h0, ch_pin_out}, {27'h0, m_pins()});
      chk("R10 irq", {31'h0, irq}, {31'h0, m_irq()});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2;
    int high;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    live = 1;
    // R1 reset state
    rd("R1 ctrl", 5'd0, v);  chk("R1 ctrl zero", {16'h0, v}, 0);
    rd("R1 flags", 5'd1, v); chk("R1 flags zero", {16'h0, v}, 0);
    rd("R1 cnt", 5'd2, v);   chk("R1 cnt zero", {16'h0, v}, 0);
    rd("R1 val", 5'd16, v);
    chk("R1 pins low", {27'h0, ch_pin_out}, 0);
    chk("R1 irq low", {31'h0, irq}, 0);

    // R2 divide-by-6 and divide-by-2 sources
    wr(5'd0, 16'h0004); idle(40);
    rd("R2 slow source", 5'd2, v);
    wr(5'd0, 16'h0001); wr(5'd2, 16'h0000);
    wr(5'd0, 16'h0005); idle(21);
    rd("R2 fast source", 5'd2, v);
    // R3 stop holds
    wr(5'd0, 16'h0001);
    rd("R3 stopped", 5'd2, v); idle(10);
    rd("R3 stopped later", 5'd2, v2);
    chk("R3 hold", {16'h0, v2}, {16'h0, v});

    // R2 neighbouring-timer pulses
    wr(5'd2, 16'h0100); wr(5'd0, 16'h0006);
    pulse_tmr(4); idle(2);
    rd("R2 tmr source", 5'd2, v); chk("R2 tmr four steps", {16'h0, v}, 32'h0104);
    wr(5'd0, 16'h0002); pulse_tmr(3);
    rd("R3 tmr gated", 5'd2, v); chk("R3 no step when stopped", {16'h0, v}, 32'h0104);

    // R2 external count pin
    wr(5'd2, 16'h0000); wr(5'd0, 16'h0007);
    for (int k = 0; k < 4; k++) begin
      ext_cnt_in = 1'b1; idle(3); ext_cnt_in = 1'b0; idle(3);
    end
    idle(4);
    rd("R2 ext source", 5'd2, v); chk("R2 ext four edges", {16'h0, v}, 4);

    // R5 capture: ch0 rise, ch1 fall, ch2 both
    wr(5'd1, 16'h003F); wr(5'd2, 16'h0000); wr(5'd0, 16'h0005);
    wr(5'd8, 16'h0009); wr(5'd9, 16'h0011); wr(5'd10, 16'h0019);
    idle(5);
    ch_pin_in = 5'b00111; idle(6);
    rd("R5 ch0 rise", 5'd16, v); rd("R5 ch1 idle", 5'd17, v2);
    chk("R5 fall-only ignores rise", {16'h0, v2}, 0);
    rd("R5 ch2 rise", 5'd18, v);
    rd("R5 flags after rise", 5'd1, v); chk("R5 rise flags", {16'h0, v}, 32'h5);
    ch_pin_in = 5'b00000; idle(6);
    rd("R5 ch0 kept", 5'd16, v); rd("R5 ch1 fall", 5'd17, v);
    rd("R5 ch2 fall", 5'd18, v);
    rd("R5 flags after fall", 5'd1, v); chk("R5 fall flags", {16'h0, v}, 32'h7);
    wr(5'd8, 16'h0); wr(5'd9, 16'h0); wr(5'd10, 16'h0);

    // R6 timer on ch3 with irq, R7 toggle on ch4
    wr(5'd1, 16'h003F); wr(5'd0, 16'h0002); wr(5'd2, 16'h0200);
    wr(5'd19, 16'h0203); wr(5'd20, 16'h0203);
    wr(5'd11, 16'h0022); wr(5'd12, 16'h0003); wr(5'd0, 16'h0006);
    pulse_tmr(2);
    rd("R6 before match", 5'd1, v); chk("R6 no early flag", {16'h0, v}, 0);
    chk("R7 pin before match", {31'h0, ch_pin_out[4]}, 0);
    pulse_tmr(1);
    rd("R6 at match", 5'd1, v); chk("R6 R7 match flags", {16'h0, v}, 32'h18);
    chk("R7 pin toggled", {31'h0, ch_pin_out[4]}, 1);
    chk("R10 irq from ch3", {31'h0, irq}, 1);
    pulse_tmr(1);
    chk("R7 pin holds past match", {31'h0, ch_pin_out[4]}, 1);

    // R4 with R6 on the same edge
    wr(5'd1, 16'h003F); wr(5'd0, 16'h000A); wr(5'd12, 16'h0000);
    wr(5'd2, 16'hFFFE); wr(5'd19, 16'h0000); wr(5'd0, 16'h000E);
    pulse_tmr(1);
    rd("R4 before wrap", 5'd1, v); chk("R4 no flag yet", {16'h0, v}, 0);
    pulse_tmr(1);
    rd("R4 wrap", 5'd1, v); chk("R4 R6 same edge", {16'h0, v}, 32'h28);
    chk("R10 irq on", {31'h0, irq}, 1);
    wr(5'd1, 16'h0020);
    rd("R9 partial clear", 5'd1, v); chk("R9 keep ch3", {16'h0, v}, 32'h08);
    chk("R10 irq still on", {31'h0, irq}, 1);
    wr(5'd1, 16'h0008);
    chk("R10 irq off", {31'h0, irq}, 0);
    // R9 set beats clear
    wr(5'd2, 16'hFFFF);
    tmr_ovf_in = 1'b1; wr_en = 1'b1; wr_addr = 5'd1; wr_data = 16'h0020;
    @(negedge clk);
    tmr_ovf_in = 1'b0; wr_en = 1'b0;
    rd("R9 set wins", 5'd1, v); chk("R9 set wins value", {16'h0, v}, 32'h28);
    wr(5'd11, 16'h0000); wr(5'd1, 16'h003F); wr(5'd0, 16'h0000);

    // R8 PWM on ch3
    wr(5'd11, 16'h0004); wr(5'd19, 16'h4000); wr(5'd0, 16'h0005);
    idle(600);
    high = 0;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      if (ch_pin_out[3]) high++;
    end
    chk("R8 duty 0x40", high, 384);
    wr(5'd19, 16'hC000); idle(600);
    high = 0;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      if (ch_pin_out[3]) high++;
    end
    chk("R8 duty 0xC0", high, 128);

    idle(2);
    finish_run();
  end

endmodule